// File: doc/BRIEF.md
# JPEG Marker Segment Parser

This block reads a baseline JPEG byte stream one byte per accepted transfer and walks its marker structure. Bytes arriving before a start-of-image marker are thrown away without comment, so the block can pick up a stream part-way through or after corruption. Once synchronised it recognises the frame, scan, table, restart-interval, line-count, comment and application segments. It reads each two-byte length, which includes itself, and steps over exactly that many bytes minus two.

A five-bit class mask, captured when a stream's first byte is accepted, picks which segment classes are copied, marker and length included, to an 8-bit side port. Any set mask bit also copies the start- and end-of-image markers, and the block raises a flag alongside their code bytes. The side port holds each byte until the consumer takes it. When the side buffer has little room left, the block lowers its input ready.

A start-of-scan segment ends marker parsing. The block pulses a scan-start output and waits for the scan decoder to report completion. An end-of-image marker returns the block to idle. A malformed stream sets a sticky error flag and stops input until a clear.

Top module: `jpeg_marker_parser`

## Requirements
- R1: After reset, in_ready is 1, side_avail is 0, err_flags is 0 and scan_start is 0.
- R2: From idle, every byte before the pair 0xFF,0xD8 is discarded: nothing is forwarded and no error is raised.
- R3: A segment marker is followed by a big-endian 16-bit length that counts itself, and exactly length−2 further bytes belong to the segment. Recognised codes are 0xC0, 0xC4, 0xDB, 0xDD, 0xDA, 0xDC, 0xFE and 0xE0–0xEF. Extra 0xFF fill bytes before a marker code are skipped.
- R4: A segment is forwarded (0xFF, code, both length bytes, payload) only when its class bit in the latched mask is 1. The classes are bit 4 for 0xC0/0xDA/0xDC, bit 3 for 0xFE/0xE0–0xEF, bit 2 for 0xDD, bit 1 for 0xDB and bit 0 for 0xC4.
- R5: When any latched mask bit is 1, the 0xFF,0xD8 and 0xFF,0xD9 marker pairs are forwarded. side_soi is 1 only with the 0xD8 byte and side_eoi only with the 0xD9 byte.
- R6: fwd_mask is latched when the first byte of a stream is accepted in idle. Later changes have no effect until the next stream.
- R7: A byte on the side port stays unchanged while side_next is 0, and in_ready is 0 while fewer than two side buffer slots are free. No forwarded byte is lost or reordered.
- R8: A marker code 0xC1–0xC3, 0xC5–0xC7, 0xC9–0xCB or 0xCD–0xCF sets err_flags bit 0. Any other unrecognised code (including 0xD0–0xD7, 0xC8, 0xCC, a repeated 0xD8) or a non-0xFF byte where a marker is due sets bit 1. A length below 2 sets bit 2. Once a flag is set, in_ready stays 0.
- R9: A cycle of clr clears err_flags, empties the side buffer and returns the block to idle.
- R10: When the last byte of a 0xDA segment is accepted, scan_start pulses for one cycle and in_ready stays 0 until scan_done. After that the block expects the next marker.
- R11: Accepting 0xD9 as a marker code returns the block to idle with in_ready 1, and the next stream hunts for 0xFF,0xD8 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear to idle |
| in_byte | input | 8 | Stream byte |
| in_strobe | input | 1 | in_byte is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| fwd_mask | input | 5 | Segment class forwarding mask |
| side_byte | output | 8 | Forwarded byte |
| side_avail | output | 1 | side_byte is valid |
| side_next | input | 1 | Consumer takes the side byte |
| side_soi | output | 1 | Side byte is the start-of-image code |
| side_eoi | output | 1 | Side byte is the end-of-image code |
| scan_start | output | 1 | One-cycle pulse: scan header finished |
| scan_done | input | 1 | Scan decoder finished; resume parsing |
| err_flags | output | 3 | Sticky errors: frame type, illegal marker, bad length |

## Verification
A byte is accepted on the rising edge where in_strobe and in_ready are both 1. For a forwarded marker, the 0xFF byte is at the side port right after that edge and the code byte one edge later. Length and payload bytes appear right after their own accepting edge. err_flags, scan_start and the drop of in_ready follow the edge that accepts the offending or final byte. The bench drives and samples on falling edges and records side bytes on the falling edge before the edge that pops them. It waits twelve cycles after each stream before it compares results, which is longer than any drain of the buffer.

// File: rtl/jmp_pkg.sv
// Shared constants and types for the JPEG marker segment parser.
// Assumes byte-serial input and a 16-bit segment length field.
package jmp_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2 * BYTE_W;
    localparam int MASK_W = 5;
    localparam int ERR_W  = 3;

    // Mask bit positions per segment class (external contract).
    localparam int MB_HUFF     = 0;
    localparam int MB_QUANT    = 1;
    localparam int MB_INTERVAL = 2;
    localparam int MB_TEXT     = 3;
    localparam int MB_FRAME    = 4;

    // Error flag positions.
    localparam int EB_FRAME  = 0;
    localparam int EB_MARKER = 1;
    localparam int EB_LENGTH = 2;

    localparam logic [BYTE_W-1:0] CODE_PREFIX = 8'hFF;
    localparam logic [BYTE_W-1:0] CODE_SOI    = 8'hD8;
    localparam logic [BYTE_W-1:0] CODE_EOI    = 8'hD9;

    typedef enum logic [3:0] {
        MC_SOI, MC_EOI, MC_SOF0, MC_SOFX, MC_SOS, MC_DNL, MC_DQT,
        MC_DHT, MC_DRI, MC_COM, MC_APP, MC_FILL, MC_BAD
    } mclass_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HUNT, ST_HUNT_CODE, ST_MK_FF, ST_MK_CODE,
        ST_LEN_HI, ST_LEN_LO, ST_BODY, ST_HANDOFF, ST_HALT
    } pstate_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              soi;
        logic              eoi;
    } side_ent_t;
endpackage

// File: rtl/jmp_marker_class.sv
// Marker code classifier: maps the byte after 0xFF to a segment class
// and to the mask bit that controls its forwarding.
// Assumes baseline-only streams; purely combinational.
module jmp_marker_class
    import jmp_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output mclass_t           cls,
    output logic [2:0]        mask_bit
);
    // Decode the marker code into a class and its mask bit.
    always_comb begin
        cls      = MC_BAD;
        mask_bit = 3'(MB_FRAME);
        case (code)
            8'hD8: cls = MC_SOI;
            8'hD9: cls = MC_EOI;
            8'hC0: cls = MC_SOF0;
            8'hDA: cls = MC_SOS;
            8'hDC: cls = MC_DNL;
            8'hC4: begin cls = MC_DHT; mask_bit = 3'(MB_HUFF);     end
            8'hDB: begin cls = MC_DQT; mask_bit = 3'(MB_QUANT);    end
            8'hDD: begin cls = MC_DRI; mask_bit = 3'(MB_INTERVAL); end
            8'hFE: begin cls = MC_COM; mask_bit = 3'(MB_TEXT);     end
            8'hFF: cls = MC_FILL;
            default: begin
                if (code[7:4] == 4'hE) begin
                    cls      = MC_APP;
                    mask_bit = 3'(MB_TEXT);
                end else if (code[7:4] == 4'hC && code[1:0] != 2'b00) begin
                    cls = MC_SOFX;
                end
            end
        endcase
    end
endmodule

// File: rtl/jmp_side_fifo.sv
// Small FIFO between the parser and the side output port.
// Holds the head entry until popped; DEPTH must be a power of two >= 2.
module jmp_side_fifo
    import jmp_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
)(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  side_ent_t push_ent,
    input  logic      pop,
    output side_ent_t head,
    output logic      avail,
    output logic [CW-1:0] level
);
    side_ent_t     mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] lvl_q;
    logic          do_push, do_pop;

    assign do_push = push && (lvl_q != CW'(DEPTH));
    assign do_pop  = pop && (lvl_q != '0);

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            lvl_q <= lvl_q + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_ent;
    end

    assign head  = mem[rp_q];
    assign avail = (lvl_q != '0);
    assign level = lvl_q;
endmodule

// File: rtl/jpeg_marker_parser.sv
// JPEG marker segment parser: hunts for SOI, walks marker segments by
// their length fields, forwards masked classes to a side port, hands
// off at SOS and returns to idle at EOI. Errors are sticky until clr.
// Assumes one input byte per strobe/ready handshake.
module jpeg_marker_parser
    import jmp_pkg::*;
#(
    parameter  int FIFO_DEPTH = 4,
    localparam int CW         = $clog2(FIFO_DEPTH) + 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_strobe,
    output logic              in_ready,
    input  logic [MASK_W-1:0] fwd_mask,
    output logic [BYTE_W-1:0] side_byte,
    output logic              side_avail,
    input  logic              side_next,
    output logic              side_soi,
    output logic              side_eoi,
    output logic              scan_start,
    input  logic              scan_done,
    output logic [ERR_W-1:0]  err_flags
);
    pstate_t           state_q, nxt;
    logic [MASK_W-1:0] mask_q;
    logic              seg_fwd_q, seg_fwd_nxt;
    logic              seg_sos_q, seg_sos_nxt;
    logic [BYTE_W-1:0] len_hi_q;
    logic [LEN_W-1:0]  remain_q, remain_nxt, seg_len;
    logic              pend_q, pend_set;
    side_ent_t         pend_ent_q, pend_nxt;
    logic [ERR_W-1:0]  err_q, err_set;
    logic              scan_q, scan_fire;
    logic              mask_ld, seg_done, take, accept_state;
    logic              push_req;
    side_ent_t         push_ent, head;
    logic [CW-1:0]     fill_level;
    mclass_t           cls;
    logic [2:0]        mask_bit;

    jmp_marker_class u_class (
        .code     (in_byte),
        .cls      (cls),
        .mask_bit (mask_bit)
    );

    jmp_side_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (clr),
        .push     (push_req),
        .push_ent (push_ent),
        .pop      (side_next),
        .head     (head),
        .avail    (side_avail),
        .level    (fill_level)
    );

    // Input is taken only in parsing states, with no pending code and room for two.
    assign accept_state = (state_q != ST_HANDOFF) && (state_q != ST_HALT);
    assign in_ready     = accept_state && !pend_q &&
                          (fill_level <= CW'(FIFO_DEPTH - 2));
    assign take         = in_strobe && in_ready;
    assign seg_len      = {len_hi_q, in_byte};

    // Next-state, forwarding and error decisions for the accepted byte.
    always_comb begin
        nxt         = state_q;
        push_req    = 1'b0;
        push_ent    = '{data: in_byte, soi: 1'b0, eoi: 1'b0};
        pend_set    = 1'b0;
        pend_nxt    = pend_ent_q;
        err_set     = '0;
        remain_nxt  = remain_q;
        scan_fire   = 1'b0;
        seg_fwd_nxt = seg_fwd_q;
        seg_sos_nxt = seg_sos_q;
        mask_ld     = 1'b0;
        seg_done    = 1'b0;
        if (pend_q) begin
            push_req = 1'b1;
            push_ent = pend_ent_q;
        end
        if (take) begin
            case (state_q)
                ST_IDLE, ST_HUNT: begin
                    mask_ld = (state_q == ST_IDLE);
                    nxt     = (in_byte == CODE_PREFIX) ? ST_HUNT_CODE : ST_HUNT;
                end
                ST_HUNT_CODE: begin
                    if (in_byte == CODE_SOI) begin
                        nxt = ST_MK_FF;
                        if (|mask_q) begin
                            push_req = 1'b1;
                            push_ent = '{data: CODE_PREFIX, soi: 1'b0, eoi: 1'b0};
                            pend_set = 1'b1;
                            pend_nxt = '{data: CODE_SOI, soi: 1'b1, eoi: 1'b0};
                        end
                    end else if (in_byte != CODE_PREFIX) begin
                        nxt = ST_HUNT;
                    end
                end
                ST_MK_FF: begin
                    if (in_byte == CODE_PREFIX) begin
                        nxt = ST_MK_CODE;
                    end else begin
                        err_set[EB_MARKER] = 1'b1;
                        nxt                = ST_HALT;
                    end
                end
                ST_MK_CODE: begin
                    case (cls)
                        MC_FILL: ;
                        MC_EOI: begin
                            nxt = ST_IDLE;
                            if (|mask_q) begin
                                push_req = 1'b1;
                                push_ent = '{data: CODE_PREFIX, soi: 1'b0, eoi: 1'b0};
                                pend_set = 1'b1;
                                pend_nxt = '{data: CODE_EOI, soi: 1'b0, eoi: 1'b1};
                            end
                        end
                        MC_SOFX: begin
                            err_set[EB_FRAME] = 1'b1;
                            nxt               = ST_HALT;
                        end
                        MC_SOI, MC_BAD: begin
                            err_set[EB_MARKER] = 1'b1;
                            nxt                = ST_HALT;
                        end
                        default: begin
                            nxt         = ST_LEN_HI;
                            seg_fwd_nxt = mask_q[mask_bit];
                            seg_sos_nxt = (cls == MC_SOS);
                            if (mask_q[mask_bit]) begin
                                push_req = 1'b1;
                                push_ent = '{data: CODE_PREFIX, soi: 1'b0, eoi: 1'b0};
                                pend_set = 1'b1;
                                pend_nxt = '{data: in_byte, soi: 1'b0, eoi: 1'b0};
                            end
                        end
                    endcase
                end
                ST_LEN_HI: begin
                    push_req = seg_fwd_q;
                    nxt      = ST_LEN_LO;
                end
                ST_LEN_LO: begin
                    if (seg_len < LEN_W'(2)) begin
                        err_set[EB_LENGTH] = 1'b1;
                        nxt                = ST_HALT;
                    end else begin
                        push_req   = seg_fwd_q;
                        remain_nxt = seg_len - LEN_W'(2);
                        if (seg_len == LEN_W'(2)) seg_done = 1'b1;
                        else                      nxt      = ST_BODY;
                    end
                end
                ST_BODY: begin
                    push_req   = seg_fwd_q;
                    remain_nxt = remain_q - LEN_W'(1);
                    if (remain_q == LEN_W'(1)) seg_done = 1'b1;
                end
                default: ;
            endcase
        end
        if (seg_done) begin
            if (seg_sos_q) begin
                nxt       = ST_HANDOFF;
                scan_fire = 1'b1;
            end else begin
                nxt = ST_MK_FF;
            end
        end
        if (state_q == ST_HANDOFF && scan_done) nxt = ST_MK_FF;
    end

    // State, segment context, pending code and sticky error registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q    <= ST_IDLE;
            mask_q     <= '0;
            seg_fwd_q  <= 1'b0;
            seg_sos_q  <= 1'b0;
            len_hi_q   <= '0;
            remain_q   <= '0;
            pend_q     <= 1'b0;
            pend_ent_q <= '0;
            err_q      <= '0;
            scan_q     <= 1'b0;
        end else begin
            state_q   <= nxt;
            seg_fwd_q <= seg_fwd_nxt;
            seg_sos_q <= seg_sos_nxt;
            remain_q  <= remain_nxt;
            pend_q    <= pend_set;
            err_q     <= err_q | err_set;
            scan_q    <= scan_fire;
            if (pend_set) pend_ent_q <= pend_nxt;
            if (mask_ld)  mask_q     <= fwd_mask;
            if (take && state_q == ST_LEN_HI) len_hi_q <= in_byte;
        end
    end

    assign side_byte  = head.data;
    assign side_soi   = side_avail && head.soi;
    assign side_eoi   = side_avail && head.eoi;
    assign scan_start = scan_q;
    assign err_flags  = err_q;
endmodule

// File: rtl/jmp_checker.sv
// Property checker for the JPEG marker segment parser, bound to the top.
// Observes ports and the side buffer occupancy.
module jmp_checker
    import jmp_pkg::*;
#(
    parameter  int FIFO_DEPTH = 4,
    localparam int CW         = $clog2(FIFO_DEPTH) + 1
)(
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_ready,
    input logic [BYTE_W-1:0] side_byte,
    input logic              side_avail,
    input logic              side_next,
    input logic              side_soi,
    input logic              side_eoi,
    input logic              scan_start,
    input logic [ERR_W-1:0]  err_flags,
    input logic [CW-1:0]     fill_level
);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (side_avail && !side_next && !clr) |=> (side_avail && $stable(side_byte)));

    assert_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level >= CW'(FIFO_DEPTH - 1)) |-> !in_ready);

    assert_soi_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        side_soi |-> (side_byte == CODE_SOI));

    assert_eoi_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        side_eoi |-> (side_byte == CODE_EOI));

    assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != '0) |-> !in_ready);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags != '0) && !clr) |=> $stable(err_flags));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((err_flags == '0) && !side_avail && !scan_start));

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |=> !scan_start);
endmodule

bind jpeg_marker_parser jmp_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_jmp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .in_ready   (in_ready),
    .side_byte  (side_byte),
    .side_avail (side_avail),
    .side_next  (side_next),
    .side_soi   (side_soi),
    .side_eoi   (side_eoi),
    .scan_start (scan_start),
    .err_flags  (err_flags),
    .fill_level (fill_level)
);

// File: tb/tb_jpeg_marker_parser.sv
module tb_jpeg_marker_parser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, clr = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_strobe = 1'b0, in_ready;
    logic [4:0] fwd_mask = '0;
    logic [7:0] side_byte;
    logic       side_avail, side_next = 1'b0, side_soi, side_eoi;
    logic       scan_start, scan_done = 1'b0;
    logic [2:0] err_flags;

    always #5 clk = ~clk;

    jpeg_marker_parser dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_byte(in_byte),
        .in_strobe(in_strobe), .in_ready(in_ready), .fwd_mask(fwd_mask),
        .side_byte(side_byte), .side_avail(side_avail), .side_next(side_next),
        .side_soi(side_soi), .side_eoi(side_eoi), .scan_start(scan_start),
        .scan_done(scan_done), .err_flags(err_flags)
    );

    int checks = 0, fails = 0;
    logic [7:0] rec_b [64];
    bit         rec_s [64];
    bit         rec_e [64];
    int         rec_n = 0, scan_n = 0;

    // Stream vectors: bytes packed first-byte-high, forwarded bytes expected.
    localparam int NV = 12;
    localparam logic [127:0] V_BYTES [NV] = '{
        128'h1234FFD8FFFE0004AABBFFD900000000,
        128'hFFD8FFE1000355FFDB0002FFD9000000,
        128'hFFD8FFFFDB000307FFDD00040102FFD9,
        128'hFFD8FFDD00040010FFC40002FFD90000,
        128'hFFD8FFC4000309FFFE0002FFD9000000,
        128'hFFD8FFC0000311FFDA00032200000000,
        128'hFFD8FFC2000000000000000000000000,
        128'hFFD8FFD3000000000000000000000000,
        128'hFFD8FFFE000100000000000000000000,
        128'hFFD85500000000000000000000000000,
        128'hFFD8FFDC00040100FFD9000000000000,
        128'hFFD8FFD9000000000000000000000000
    };
    localparam int V_LEN [NV] = '{12, 13, 16, 14, 13, 12, 4, 4, 6, 3, 10, 4};
    localparam logic [4:0] V_MASK [NV] = '{5'h00, 5'h08, 5'h02, 5'h04, 5'h01,
        5'h10, 5'h00, 5'h00, 5'h00, 5'h00, 5'h10, 5'h1F};
    localparam logic [127:0] V_EXP [NV] = '{
        128'h0,
        128'hFFD8FFE1000355FFD900000000000000,
        128'hFFD8FFDB000307FFD900000000000000,
        128'hFFD8FFDD00040010FFD9000000000000,
        128'hFFD8FFC4000309FFD900000000000000,
        128'hFFD8FFC0000311FFDA00032200000000,
        128'h0, 128'h0, 128'h0, 128'h0,
        128'hFFD8FFDC00040100FFD9000000000000,
        128'hFFD8FFD9000000000000000000000000
    };
    localparam int V_ECNT [NV] = '{0, 9, 9, 10, 9, 12, 0, 0, 0, 0, 10, 4};
    localparam int V_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 1, 2, 4, 2, 0, 0};
    localparam int V_SCAN [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
    localparam int V_EOI  [NV] = '{0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1, 1};
    localparam int V_RDY  [NV] = '{1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1, 1};

    function automatic logic [7:0] byte_at(input logic [127:0] v, input int i);
        return v[127 - 8*i -: 8];
    endfunction

    function automatic string row_req(input int i);
        case (i)
            0:          return "R2";
            2, 10:      return "R3";
            5:          return "R10";
            6, 7, 8, 9: return "R8";
            11:         return "R5";
            default:    return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Record each side byte on the falling edge before the edge that pops it.
    always @(negedge clk) begin
        if (side_avail && side_next && rec_n < 64) begin
            rec_b[rec_n] = side_byte;
            rec_s[rec_n] = side_soi;
            rec_e[rec_n] = side_eoi;
            rec_n++;
        end
        if (scan_start) scan_n++;
    end

    task automatic send(input logic [7:0] b);
        in_byte   = b;
        in_strobe = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_strobe = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_drain(input logic v);
        @(posedge clk); #1 side_next = v;
        @(negedge clk);
    endtask

    task automatic restart();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(posedge clk); #1 rec_n = 0; scan_n = 0;
        @(negedge clk);
    endtask

    task automatic check_stream(input logic [127:0] exp, input int cnt, input string req);
        chk(rec_n == cnt, req, rec_n, cnt);
        for (int k = 0; k < cnt && k < rec_n; k++)
            chk(rec_b[k] == byte_at(exp, k), req, rec_b[k], byte_at(exp, k));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        chk(side_avail == 1'b0, "R1", side_avail, 0);
        chk(err_flags == 3'b000, "R1", err_flags, 0);
        chk(scan_start == 1'b0, "R1", scan_start, 0);

        set_drain(1'b1);
        for (int i = 0; i < NV; i++) begin
            int soi_n, eoi_n;
            restart();
            fwd_mask = V_MASK[i];
            for (int k = 0; k < V_LEN[i]; k++) send(byte_at(V_BYTES[i], k));
            wait_n(12);
            check_stream(V_EXP[i], V_ECNT[i], row_req(i));
            chk(err_flags == 3'(V_ERR[i]), "R8", err_flags, V_ERR[i]);
            chk(scan_n == V_SCAN[i], "R10", scan_n, V_SCAN[i]);
            soi_n = 0; eoi_n = 0;
            for (int k = 0; k < rec_n; k++) begin
                if (rec_s[k]) soi_n++;
                if (rec_e[k]) eoi_n++;
            end
            chk(soi_n == ((V_ECNT[i] > 0) ? 1 : 0), "R5", soi_n, (V_ECNT[i] > 0) ? 1 : 0);
            chk(eoi_n == V_EOI[i], "R5", eoi_n, V_EOI[i]);
            chk(in_ready == V_RDY[i][0], "R11", in_ready, V_RDY[i]);
        end

        // R7: side byte held and input stalled when the buffer fills
        restart();
        set_drain(1'b0);
        fwd_mask = 5'h08;
        send(8'hFF); send(8'hD8); send(8'hFF); send(8'hFE);
        wait_n(3);
        chk(in_ready == 1'b0, "R7", in_ready, 0);
        chk(side_avail && side_byte == 8'hFF, "R7", side_byte, 8'hFF);
        wait_n(2);
        chk(side_byte == 8'hFF, "R7", side_byte, 8'hFF);
        set_drain(1'b1);
        send(8'h00); send(8'h02); send(8'hFF); send(8'hD9);
        wait_n(12);
        check_stream(128'hFFD8FFFE0002FFD90000000000000000, 8, "R7");

        // R6: mask change after the first byte has no effect
        restart();
        fwd_mask = 5'h00;
        send(8'hFF); send(8'hD8);
        fwd_mask = 5'h1F;
        send(8'hFF); send(8'hFE); send(8'h00); send(8'h02); send(8'hFF); send(8'hD9);
        wait_n(12);
        chk(rec_n == 0, "R6", rec_n, 0);

        // R10: hand-off holds input until scan_done, then parsing resumes
        restart();
        fwd_mask = 5'h10;
        send(8'hFF); send(8'hD8); send(8'hFF); send(8'hDA); send(8'h00); send(8'h02);
        wait_n(4);
        chk(in_ready == 1'b0, "R10", in_ready, 0);
        chk(scan_n == 1, "R10", scan_n, 1);
        scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
        chk(in_ready == 1'b1, "R10", in_ready, 1);
        send(8'hFF); send(8'hD9);
        wait_n(12);
        check_stream(128'hFFD8FFDA0002FFD90000000000000000, 8, "R10");
        chk(rec_n == 8 && rec_e[7], "R5", rec_e[7], 1);
        chk(in_ready == 1'b1, "R11", in_ready, 1);

        // R9: clr removes a sticky error
        restart();
        send(8'hFF); send(8'hD8); send(8'hFF); send(8'hD3);
        wait_n(2);
        chk(err_flags == 3'b010 && !in_ready, "R8", err_flags, 2);
        restart();
        chk(err_flags == 3'b000, "R9", err_flags, 0);
        chk(in_ready == 1'b1, "R9", in_ready, 1);
        chk(side_avail == 1'b0, "R9", side_avail, 0);

        // R11: after EOI a new stream hunts again and re-samples the mask
        restart();
        fwd_mask = 5'h1F;
        send(8'hFF); send(8'hD8); send(8'hFF); send(8'hD9);
        fwd_mask = 5'h00;
        send(8'h55); send(8'hFF); send(8'hD8); send(8'hFF); send(8'hD9);
        wait_n(12);
        check_stream(128'hFFD8FFD9000000000000000000000000, 4, "R11");
        chk(err_flags == 3'b000, "R11", err_flags, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule